// File: doc/BRIEF.md
# EEPROM Word Program Sequencer

This block fronts an on-chip EEPROM array with a single bus port that reaches two windows. The register window holds the program mode, the clock divider, the power-down control and the status and status-clear registers. The memory window gives 32-bit word access on a 4-byte stride. The array is organised in 128-byte pages and is modelled here as a register file.

In word program mode, one word written to the memory window starts an erase/program cycle. The new word lands in the array only when the cycle ends. The cycle is timed in ticks of a divided EEPROM clock. The divider register holds the division factor minus one. The default cycle length is 4500 ticks, which is 3 ms at a 1.5 MHz tick, and the tick must stay between 800 kHz and 1600 kHz. When a cycle ends, a sticky end-of-program flag is raised, and software clears it through a separate write-one-to-clear register. The array only accepts accesses once it has been woken from power-down and a wake-up delay has passed.

Top module: `eeprom_prog_seq`

## Requirements
- R1: After reset the program mode register (0x00C) reads 0, the divider register (0x014) reads 0, the power-down register (0x018) reads 1 and the status register (0xFE0) reads 0.
- R2: The divider register value d gives one EEPROM tick every d+1 bus cycles. A program cycle lasts PROG_TICKS ticks, so busy stays set for between (PROG_TICKS-1)*(d+1) and PROG_TICKS*(d+1) bus cycles.
- R3: With the mode register at 1 (word mode), an accepted memory-window write starts a program cycle. Status bit 1 (busy) reads 1 during the cycle. The addressed word keeps its old value until the cycle ends, and then holds the new value.
- R4: The end of a program cycle sets status bit 2. The bit stays set until it is cleared.
- R5: Writing the clear register (0xFE8) with bit 2 at 1 clears status bit 2. Writing it with bit 2 at 0 leaves status bit 2 set.
- R6: A memory-window write that arrives during a program cycle is ignored, leaves the array unchanged and sets status bit 0 (error).
- R7: While the power-down register is 1, a memory-window write is ignored and sets status bit 0, and a memory-window read returns zero.
- R8: After 0 is written to the power-down register, the array stays inaccessible for WAKE_CYCLES bus cycles, with the same behaviour as under R7. After that delay, accesses are accepted.
- R9: With the mode register at any value other than 1, an accepted memory-window write stores the word at once. It starts no cycle and leaves status bit 2 at 0.
- R10: Read data appears one cycle after the request, with the read-valid output high for that cycle. Memory word index is address bits [2 +: log2(WORDS)], and address bits [1:0] are ignored.
- R11: Writing the clear register with bit 0 at 1 clears status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_mem | input | 1 | 1 selects the memory window, 0 selects the register window |
| bus_addr | input | ADDR_W | Byte address within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High one cycle after a read request |

## Verification
The bench measures the busy window of program cycles for several divider values. A divider that was off by one, or a cycle counter that ended a tick early or late, would move completion outside the allowed window. It reads the target word while a cycle is still running, so a design that committed data at the start of the cycle would return the new word too early. It also writes during busy, during power-down and inside the wake-up delay, and checks that the array word is unchanged and the error bit is set. A gate that leaked any of these writes would corrupt the array. Finally, it clears status bits with both 0 and 1 patterns, which catches a clear register that acts on the wrong bit or clears on any write.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  localparam logic [11:0] OFF_MODE  = 12'h00C;
  localparam logic [11:0] OFF_DIV   = 12'h014;
  localparam logic [11:0] OFF_PWR   = 12'h018;
  localparam logic [11:0] OFF_STAT  = 12'hFE0;
  localparam logic [11:0] OFF_CLR   = 12'hFE8;

  localparam int ST_ERR  = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_END  = 2;

  localparam logic [1:0] MODE_WORD = 2'd1;

  function automatic logic is_word_mode(input logic [1:0] mode);
    return mode == MODE_WORD;
  endfunction

  function automatic logic [31:0] stat_word(input logic end_f, input logic busy_f, input logic err_f);
    logic [31:0] w;
    w = '0;
    w[ST_END]  = end_f;
    w[ST_BUSY] = busy_f;
    w[ST_ERR]  = err_f;
    return w;
  endfunction
endpackage

// File: rtl/eeprom_tick_div.sv
module eeprom_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
  parameter int PROG_TICKS = 4500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_TICKS + 1);
  logic [CW-1:0] cnt;

  assign done = busy && tick && (cnt == CW'(PROG_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && tick) begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/eeprom_word_array.sv
module eeprom_word_array #(
  parameter int WORDS = 64,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
  import eeprom_seq_pkg::*;
#(
  parameter int WORDS       = 64,
  parameter int ADDR_W      = 12,
  parameter int DIV_W       = 8,
  parameter int PROG_TICKS  = 4500,
  parameter int WAKE_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_mem,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int IW = $clog2(WORDS);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic [1:0]       mode_q;
  logic [DIV_W-1:0] div_q;
  logic             pwr_dn_q;
  logic [WW-1:0]    wake_cnt;
  logic             st_end, st_err;
  logic [IW-1:0]    pend_idx;
  logic [31:0]      pend_data;

  logic tick, busy, done, awake, mem_ok;
  logic reg_wr, mem_wr, rd_req, start_pgm, direct_wr, mem_reject;
  logic clr_end, clr_err;
  logic          arr_we;
  logic [IW-1:0] arr_waddr, bus_idx;
  logic [31:0]   arr_wdata, arr_rdata, rd_next;

  assign bus_idx    = bus_addr[2 +: IW];
  assign reg_wr     = bus_valid && bus_write && !bus_mem;
  assign mem_wr     = bus_valid && bus_write && bus_mem;
  assign rd_req     = bus_valid && !bus_write;
  assign awake      = !pwr_dn_q && (wake_cnt == '0);
  assign mem_ok     = awake && !busy;
  assign start_pgm  = mem_wr && mem_ok && is_word_mode(mode_q);
  assign direct_wr  = mem_wr && mem_ok && !is_word_mode(mode_q);
  assign mem_reject = mem_wr && !mem_ok;
  assign clr_end    = reg_wr && bus_addr == ADDR_W'(OFF_CLR) && bus_wdata[ST_END];
  assign clr_err    = reg_wr && bus_addr == ADDR_W'(OFF_CLR) && bus_wdata[ST_ERR];

  assign arr_we    = direct_wr || done;
  assign arr_waddr = direct_wr ? bus_idx : pend_idx;
  assign arr_wdata = direct_wr ? bus_wdata : pend_data;

  eeprom_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

  eeprom_prog_timer #(.PROG_TICKS(PROG_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_pgm), .tick(tick), .busy(busy), .done(done));

  eeprom_word_array #(.WORDS(WORDS)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(bus_idx), .rdata(arr_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      div_q    <= '0;
      pwr_dn_q <= 1'b1;
      wake_cnt <= '0;
    end else begin
      if (reg_wr && bus_addr == ADDR_W'(OFF_MODE)) mode_q <= bus_wdata[1:0];
      if (reg_wr && bus_addr == ADDR_W'(OFF_DIV))  div_q  <= bus_wdata[DIV_W-1:0];
      if (reg_wr && bus_addr == ADDR_W'(OFF_PWR)) begin
        pwr_dn_q <= bus_wdata[0];
        if (!bus_wdata[0] && pwr_dn_q) wake_cnt <= WW'(WAKE_CYCLES);
        else if (bus_wdata[0])         wake_cnt <= '0;
      end else if (wake_cnt != '0) begin
        wake_cnt <= wake_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_end    <= 1'b0;
      st_err    <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
    end else begin
      if (done)         st_end <= 1'b1;
      else if (clr_end) st_end <= 1'b0;
      if (mem_reject)   st_err <= 1'b1;
      else if (clr_err) st_err <= 1'b0;
      if (start_pgm) begin
        pend_idx  <= bus_idx;
        pend_data <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_mem) begin
      if (awake) rd_next = arr_rdata;
    end else if (bus_addr == ADDR_W'(OFF_MODE)) begin
      rd_next[1:0] = mode_q;
    end else if (bus_addr == ADDR_W'(OFF_DIV)) begin
      rd_next[DIV_W-1:0] = div_q;
    end else if (bus_addr == ADDR_W'(OFF_PWR)) begin
      rd_next[0] = pwr_dn_q;
    end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
      rd_next = stat_word(st_end, busy, st_err);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_next;
    end
  end

  // R6
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pgm |-> !busy);
  // R4
  end_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> st_end);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !clr_err) |=> st_err);
  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  // R7
  asleep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_mem && !awake) |=> bus_rdata == '0);
  // R8
  wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cnt != '0) |-> !arr_we || done);
endmodule

// File: tb/sim_eeprom_prog_seq.sv
module sim_eeprom_prog_seq;
  localparam int WORDS = 64;
  localparam int PT    = 12;
  localparam int WK    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_mem = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;

  int vec = 0, bad = 0, cyc = 0;
  logic [31:0] shadow [WORDS];
  logic [31:0] rv;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eeprom_prog_seq #(.WORDS(WORDS), .ADDR_W(12), .DIV_W(8), .PROG_TICKS(PT), .WAKE_CYCLES(WK)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write), .bus_mem(bus_mem),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  function automatic int lo_bound(input int d);
    return (PT - 1) * (d + 1);
  endfunction
  function automatic int hi_bound(input int d);
    return PT * (d + 1) + 4;
  endfunction
  function automatic logic [11:0] waddr(input int idx, input int junk);
    return 12'(idx * 4 + (junk % 4));
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic mem, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_mem = mem; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic mem, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_mem = mem; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    if (!bus_rvalid) begin
      vec++; bad++;
      $display("FAIL R10 actual=rvalid0 expected=rvalid1");
    end
    d = bus_rdata;
  endtask

  task automatic program_and_time(input int d, input int idx, input logic [31:0] val, input string req);
    int t0, el;
    logic [31:0] s;
    wr(1'b0, 12'h014, 32'(d));
    wr(1'b1, waddr(idx, 0), val);
    t0 = cyc;
    el = 0;
    for (int k = 0; k < 4000; k++) begin
      rd(1'b0, 12'hFE0, s);
      if (!s[1]) begin el = cyc - t0; break; end
    end
    chk(el >= lo_bound(d) && el <= hi_bound(d), req, 32'(el), 32'(lo_bound(d)));
    shadow[idx] = val;
  endtask

  initial begin
    begin : watchdog
      #3000000;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(1'b0, 12'h00C, rv); chk(rv == 0, "R1 mode", rv, 0);
    rd(1'b0, 12'h014, rv); chk(rv == 0, "R1 div", rv, 0);
    rd(1'b0, 12'h018, rv); chk(rv == 1, "R1 pwr", rv, 1);
    rd(1'b0, 12'hFE0, rv); chk(rv == 0, "R1 stat", rv, 0);

    // R7: asleep access
    rd(1'b1, waddr(3, 0), rv); chk(rv == 0, "R7 read asleep", rv, 0);
    wr(1'b1, waddr(3, 0), 32'hDEAD0003);
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h1, "R7 err set", rv, 32'h1);
    wr(1'b0, 12'hFE8, 32'h0);
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h1, "R11 clear0 keeps", rv, 32'h1);
    wr(1'b0, 12'hFE8, 32'h1);
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h0, "R11 clear", rv, 32'h0);

    // R8: wake delay
    wr(1'b0, 12'h018, 32'h0);
    wr(1'b1, waddr(5, 0), 32'hBAD00005);
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h1, "R8 early write rejected", rv, 32'h1);
    repeat (WK + 2) @(negedge clk);
    wr(1'b0, 12'hFE8, 32'h1);
    wr(1'b1, waddr(5, 1), 32'h11110005);
    shadow[5] = 32'h11110005;
    rd(1'b1, waddr(5, 3), rv); chk(rv == 32'h11110005, "R8 R9 R10 direct store", rv, 32'h11110005);
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h0, "R9 no end flag", rv, 32'h0);

    // random direct writes with mode 2 (not word mode)
    wr(1'b0, 12'h00C, 32'h2);
    for (int i = 0; i < WORDS; i++) begin
      logic [31:0] v;
      v = $urandom;
      wr(1'b1, waddr(i, int'($urandom % 4)), v);
      shadow[i] = v;
    end
    for (int i = 0; i < 40; i++) begin
      int j;
      j = int'($urandom % WORDS);
      rd(1'b1, waddr(j, int'($urandom % 4)), rv);
      chk(rv == shadow[j], "R9 R10 random readback", rv, shadow[j]);
    end

    // R3/R6: word mode program
    wr(1'b0, 12'h00C, 32'h1);
    wr(1'b1, waddr(7, 0), 32'h12345678);
    rd(1'b1, waddr(7, 0), rv); chk(rv == shadow[7], "R3 old data during cycle", rv, shadow[7]);
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h2, "R3 busy", rv, 32'h2);
    wr(1'b1, waddr(8, 0), 32'hCAFE0008);
    rd(1'b0, 12'hFE0, rv); chk(rv[0] == 1'b1, "R6 err on busy write", rv, 32'h3);
    for (int k = 0; k < 200; k++) begin
      rd(1'b0, 12'hFE0, rv);
      if (!rv[1]) break;
    end
    shadow[7] = 32'h12345678;
    rd(1'b1, waddr(7, 2), rv); chk(rv == 32'h12345678, "R3 committed", rv, 32'h12345678);
    rd(1'b1, waddr(8, 0), rv); chk(rv == shadow[8], "R6 array unchanged", rv, shadow[8]);
    wr(1'b0, 12'hFE8, 32'h1);
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h4, "R4 end sticky", rv, 32'h4);
    wr(1'b0, 12'hFE8, 32'h0);
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h4, "R5 clear with 0 keeps", rv, 32'h4);
    wr(1'b0, 12'hFE8, 32'h4);
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h0, "R5 clear", rv, 32'h0);

    // R2: timing for several dividers
    program_and_time(0, 10, 32'hA0A0A0A0, "R2 div0");
    program_and_time(2, 11, $urandom, "R2 div2");
    program_and_time(5, 12, $urandom, "R2 div5");
    program_and_time(int'($urandom % 8), 13, $urandom, "R2 divrand");
    rd(1'b0, 12'hFE0, rv); chk(rv == 32'h4, "R4 after timed", rv, 32'h4);
    for (int j = 10; j < 14; j++) begin
      rd(1'b1, waddr(j, 0), rv); chk(rv == shadow[j], "R3 timed readback", rv, shadow[j]);
    end
    wr(1'b0, 12'h014, 32'h9);
    rd(1'b0, 12'h014, rv); chk(rv == 32'h9, "R2 div readback", rv, 32'h9);

    // R7: power down again
    wr(1'b0, 12'h018, 32'h1);
    rd(1'b1, waddr(10, 0), rv); chk(rv == 0, "R7 read zero", rv, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule